// File: doc/BRIEF.md
# Return Address Stack

This block is a small last-in, first-out store for return addresses. It sits beside the sequencer and outside both the program and data address spaces. On a subroutine call or interrupt entry, the sequencer strobes `push_en` together with the program counter on `push_data`. On a return, it strobes `pop_en` and takes the saved address from `pop_data` in that same cycle.

A 5-bit pointer indexes the entries. The pointer is incremented before the write and decremented after the read. Pointer value 0 therefore means "empty", and slot 0 holds no storage. This gives 31 usable entries of 21 bits each.

Misuse is reported through sticky flags, and no stored state is corrupted:
- A push onto a full stack is dropped and raises `overflow`.
- A pop from an empty stack returns zero and raises `underflow`.

Top module: `ras_stack`

## Requirements
- R1: After synchronous reset, `sp` is 0, `full`, `overflow` and `underflow` are 0, and `pop_data` is 0.
- R2: A push alone with `sp` below 31 raises `sp` by one on the clock edge and stores `push_data` in the slot now addressed, so `pop_data` shows that value from the next cycle on.
- R3: `pop_data` always shows the slot addressed by `sp`, with no clock delay, and shows 0 when `sp` is 0. A pop alone with `sp` above 0 lowers `sp` by one on the clock edge.
- R4: Addresses come back in reverse order of their pushes, across the full depth of 31 entries.
- R5: `full` is 1 exactly when `sp` equals 31.
- R6: A push alone while `sp` is 31 leaves `sp` and every stored address unchanged, and sets `overflow`.
- R7: A pop alone while `sp` is 0 presents 0 on `pop_data`, leaves `sp` at 0, and sets `underflow`.
- R8: Push and pop together with `sp` above 0 replace the top entry with `push_data`, keep `sp` unchanged, and set no flag.
- R9: Push and pop together with `sp` at 0 set `underflow`, move `sp` to 1, and store `push_data` in entry 1.
- R10: `overflow` and `underflow` stay set until reset, whatever later pushes and pops occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Save `push_data` on the stack |
| push_data | input | 21 | Return address to save |
| pop_en | input | 1 | Remove the top entry |
| pop_data | output | 21 | Current top entry, 0 when empty |
| sp | output | 5 | Stack pointer, 0 = empty |
| full | output | 1 | High when all 31 entries are in use |
| overflow | output | 1 | Sticky: a push was dropped on a full stack |
| underflow | output | 1 | Sticky: a pop was made on an empty stack |

## Verification
The pointer and the top entry are both visible at the ports. A pointer that steps wrongly, or a write to the wrong slot, therefore shows on `sp` or `pop_data` in the first cycle after the faulty edge.

A slot corrupted below the top stays hidden until the stack drains down to it. For that reason the bench fills all 31 entries and empties them again, comparing every returned address. A flag that fails to stick is caught by reading the flags after many unrelated operations.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_ADDR_W = 21;
    localparam int RAS_PTR_W  = 5;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } ras_op_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic overflow;
        logic underflow;
    } ras_status_t;

    function automatic ras_op_e ras_decode(input logic push, input logic pop);
        ras_op_e op;
        unique case ({pop, push})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int PTR_W = RAS_PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output ras_status_t      status
);

    localparam logic [PTR_W-1:0] PTR_MAX  = '1;
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             ovf_q, udf_q;
    logic             ovf_set, udf_set;
    logic             at_top, at_bottom;
    ras_op_e          op;

    assign op        = ras_decode(push, pop);
    assign at_top    = (ptr_q == PTR_MAX);
    assign at_bottom = (ptr_q == PTR_ZERO);

    always_comb begin
        ptr_d   = ptr_q;
        wr_en   = 1'b0;
        wr_idx  = ptr_q;
        ovf_set = 1'b0;
        udf_set = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (at_top) begin
                    ovf_set = 1'b1;
                end else begin
                    ptr_d  = ptr_q + 1'b1;
                    wr_en  = 1'b1;
                    wr_idx = ptr_q + 1'b1;
                end
            end
            OP_POP: begin
                if (at_bottom) begin
                    udf_set = 1'b1;
                end else begin
                    ptr_d = ptr_q - 1'b1;
                end
            end
            OP_SWAP: begin
                // read-then-write: an empty stack underflows, then takes the push
                if (at_bottom) begin
                    udf_set = 1'b1;
                    ptr_d   = ptr_q + 1'b1;
                    wr_idx  = ptr_q + 1'b1;
                end
                wr_en = 1'b1;
            end
            default: begin
                ptr_d = ptr_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            ovf_q <= ovf_q | ovf_set;
            udf_q <= udf_q | udf_set;
        end
    end

    assign ptr              = ptr_q;
    assign status.full      = at_top;
    assign status.empty     = at_bottom;
    assign status.overflow  = ovf_q;
    assign status.underflow = udf_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    localparam int SLOTS = (1 << PTR_W) - 1;

    logic [SLOTS:1][ADDR_W-1:0] slot_q;

    for (genvar g = 1; g <= SLOTS; g++) begin : g_slot
        logic [ADDR_W-1:0] q;
        logic              hit;
        assign hit = wr_en && (wr_idx == PTR_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                q <= wr_data;
            end
        end
        assign slot_q[g] = q;
    end

    // index 0 has no storage and reads as zero
    always_comb begin
        rd_data = '0;
        for (int k = 1; k <= SLOTS; k++) begin
            if (rd_idx == PTR_W'(k)) begin
                rd_data = slot_q[k];
            end
        end
    end

endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W = RAS_ADDR_W,
    parameter int PTR_W  = RAS_PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_data,
    input  logic              pop_en,
    output logic [ADDR_W-1:0] pop_data,
    output logic [PTR_W-1:0]  sp,
    output logic              full,
    output logic              overflow,
    output logic              underflow
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] ptr;
    ras_status_t      status;

    ras_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .push   (push_en),
        .pop    (pop_en),
        .ptr    (ptr),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .status (status)
    );

    ras_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_idx  (ptr),
        .rd_data (pop_data)
    );

    assign sp        = ptr;
    assign full      = status.full;
    assign overflow  = status.overflow;
    assign underflow = status.underflow;

endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              push_en,
    input logic [ADDR_W-1:0] push_data,
    input logic              pop_en,
    input logic [ADDR_W-1:0] pop_data,
    input logic [PTR_W-1:0]  sp,
    input logic              full,
    input logic              overflow,
    input logic              underflow
);

    localparam logic [PTR_W-1:0] SP_TOP = '1;

    // R2
    a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && sp != SP_TOP) |=> (sp == $past(sp) + 1'b1));

    // R2
    a_r2_push_visible: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && sp != SP_TOP) |=> (pop_data == $past(push_data)));

    // R3
    a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && sp != '0) |=> (sp == $past(sp) - 1'b1));

    // R3
    a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sp == '0) |-> (pop_data == '0));

    // R5
    a_r5_full_flag: assert property (@(posedge clk) disable iff (rst)
        full == (sp == SP_TOP));

    // R6
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && full) |=> ($stable(sp) && $stable(pop_data) && overflow));

    // R7
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && sp == '0) |=> (sp == '0 && underflow));

    // R8
    a_r8_swap_top: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && sp != '0) |=> ($stable(sp) && pop_data == $past(push_data)));

    // R9
    a_r9_swap_empty: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && sp == '0) |=> (sp == 1 && underflow));

    // R10
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R10
    a_r10_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

endmodule

bind ras_stack ras_stack_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .push_data (push_data),
    .pop_en    (pop_en),
    .pop_data  (pop_data),
    .sp        (sp),
    .full      (full),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/test_ras_stack.sv
`timescale 1ns/1ps
module test_ras_stack;

    localparam int AW = 21;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_en = 1'b0;
    logic          pop_en = 1'b0;
    logic [AW-1:0] push_data = '0;
    logic [AW-1:0] pop_data;
    logic [PW-1:0] sp;
    logic          full, overflow, underflow;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    ras_stack i_ras_stack (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .push_data (push_data),
        .pop_en    (pop_en),
        .pop_data  (pop_data),
        .sp        (sp),
        .full      (full),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // vector: {push, pop, data[20:0], exp_sp[4:0], exp_top[20:0]}
    localparam logic [48:0] VEC [0:9] = '{
        {1'b1, 1'b0, 21'h0000A1, 5'd1, 21'h0000A1},
        {1'b1, 1'b0, 21'h1000B2, 5'd2, 21'h1000B2},
        {1'b1, 1'b0, 21'h0C00C3, 5'd3, 21'h0C00C3},
        {1'b1, 1'b1, 21'h0D00D4, 5'd3, 21'h0D00D4},
        {1'b0, 1'b1, 21'h000000, 5'd2, 21'h1000B2},
        {1'b0, 1'b0, 21'h1FFFFF, 5'd2, 21'h1000B2},
        {1'b0, 1'b1, 21'h000000, 5'd1, 21'h0000A1},
        {1'b0, 1'b1, 21'h000000, 5'd0, 21'h000000},
        {1'b1, 1'b0, 21'h0E00E5, 5'd1, 21'h0E00E5},
        {1'b0, 1'b1, 21'h000000, 5'd0, 21'h000000}
    };

    function automatic logic [AW-1:0] pat(input int i);
        logic [15:0] lo;
        lo = 16'hBEEF ^ 16'(i * 16'h0131);
        return {5'(i), lo};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive on the falling edge, sample 2 ns after the rising edge
    task automatic step(input logic p, input logic q, input logic [AW-1:0] d);
        @(negedge clk);
        push_en   = p;
        pop_en    = q;
        push_data = d;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        push_en = 1'b0;
        pop_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_reset_state();
        chk("R1", "sp", 32'(sp), 0);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "overflow", 32'(overflow), 0);
        chk("R1", "underflow", 32'(underflow), 0);
        chk("R1", "pop_data", 32'(pop_data), 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk_reset_state();

        // table walk: R2, R3, R8
        for (int v = 0; v < 10; v++) begin
            logic [48:0] e;
            e = VEC[v];
            step(e[48], e[47], e[46:26]);
            chk("R2/R3/R8", "sp", 32'(sp), 32'(e[25:21]));
            chk("R2/R3/R8", "pop_data", 32'(pop_data), 32'(e[20:0]));
            chk("R8", "no flag", 32'({overflow, underflow}), 0);
        end

        // fill to full depth: R2, R5
        do_reset();
        for (int i = 1; i <= 31; i++) begin
            step(1'b1, 1'b0, pat(i));
            chk("R2", "sp fill", 32'(sp), 32'(i));
            chk("R5", "full fill", 32'(full), (i == 31) ? 1 : 0);
        end
        chk("R2", "top after fill", 32'(pop_data), 32'(pat(31)));

        // push on full: R6
        step(1'b1, 1'b0, 21'h1FFFFF);
        chk("R6", "sp", 32'(sp), 31);
        chk("R6", "top kept", 32'(pop_data), 32'(pat(31)));
        chk("R6", "overflow", 32'(overflow), 1);
        chk("R6", "underflow clear", 32'(underflow), 0);

        // replace at full: R8
        step(1'b1, 1'b1, 21'h0ABCDE);
        chk("R8", "sp", 32'(sp), 31);
        chk("R8", "top", 32'(pop_data), 32'h0ABCDE);
        chk("R5", "full", 32'(full), 1);

        // drain with LIFO order: R4, R3
        for (int i = 31; i >= 1; i--) begin
            logic [AW-1:0] x;
            x = (i == 31) ? 21'h0ABCDE : pat(i);
            chk("R4", "returned address", 32'(pop_data), 32'(x));
            step(1'b0, 1'b1, '0);
            chk("R3", "sp drain", 32'(sp), 32'(i - 1));
        end
        chk("R3", "empty reads zero", 32'(pop_data), 0);
        chk("R10", "overflow held", 32'(overflow), 1);

        // pop on empty: R7
        step(1'b0, 1'b1, '0);
        chk("R7", "sp", 32'(sp), 0);
        chk("R7", "pop_data", 32'(pop_data), 0);
        chk("R7", "underflow", 32'(underflow), 1);

        // stickiness across activity: R10
        step(1'b1, 1'b0, 21'h000123);
        step(1'b0, 1'b1, '0);
        idle();
        chk("R10", "overflow", 32'(overflow), 1);
        chk("R10", "underflow", 32'(underflow), 1);

        // reset clears everything: R1
        do_reset();
        #2;
        chk_reset_state();

        // push+pop on empty: R9
        step(1'b1, 1'b1, 21'h013579);
        chk("R9", "sp", 32'(sp), 1);
        chk("R9", "top", 32'(pop_data), 32'h013579);
        chk("R9", "underflow", 32'(underflow), 1);
        chk("R9", "overflow", 32'(overflow), 0);
        step(1'b0, 1'b1, '0);
        chk("R9", "sp after pop", 32'(sp), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule